// File: doc/BRIEF.md
# Parallel 64-bit Self-Synchronizing Line Scrambler

This block whitens or restores the 64-bit payload of every 66-bit line block with the multiplicative polynomial 1 + x^39 + x^58. It handles a whole payload word in one clock cycle. Each bit of the word, taken from bit 0 up to bit 63, is combined with the line bits that lie 39 and 58 positions before it in the stream. A closed-form shift-and-XOR network covers all 64 bits at once, so there is no serial loop of 64 steps. At the line rate a block arrives about every 6.4 ns, so the block accepts one word on every cycle without a stall.

A mode input selects the direction for each word. When scrambling, the 58-bit history holds the last output bits of the line. When descrambling, it holds the last received bits. Because of that, a descrambler locks onto any incoming stream after one full word and needs no seed. The 2-bit sync header is never scrambled; it is delayed so that it stays aligned with its payload. All results are registered, one cycle after the input. The history advances only on valid cycles.

Top module: `blk_scrambler64`

## Requirements
- R1: A synchronous reset clears the outputs to zero with `outValid` low and the history to all zeros. The first word scrambled after reset is therefore the result the serial rule gives from a zero state, and an all-zero word gives an all-zero result.
- R2: `outValid` is high exactly one cycle after a cycle with `inValid` high, and low one cycle after a cycle with `inValid` low.
- R3: `outHeader` equals the `inHeader` of the same accepted word, unaltered and delivered in the same cycle as its payload.
- R4: With `descramble` = 0, `outData` matches the bit-serial rule applied from bit 0 to bit 63: out = in XOR s[38] XOR s[57], after which out is shifted into s[0] (s is a 58-bit shift register holding the newest bit in s[0]).
- R5: With `descramble` = 1, `outData` matches the same serial rule, except that the received bit, not the output bit, is shifted into s[0].
- R6: Words presented on consecutive cycles are all accepted, and each produces one result in order, with no bubbles.
- R7: A cycle with `inValid` low changes neither the history nor the registered outputs, whatever is on `inData`, `inHeader` and `descramble`.
- R8: In descramble mode, once one full word of a scrambled stream has been received, every later word comes out equal to the original plaintext, whatever the history was before.
- R9: The mode may change between any two accepted words. The history is always the last 58 line bits in the convention of the word just processed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Payload word present this cycle |
| descramble | input | 1 | 0 = scramble, 1 = descramble (sampled with the word) |
| inHeader | input | 2 | Sync header, passed through unchanged |
| inData | input | 64 | Payload word, bit 0 is first on the line |
| outValid | output | 1 | Result present |
| outHeader | output | 2 | Delayed sync header |
| outData | output | 64 | Scrambled or descrambled payload |

## Verification
Every result is due exactly one clock after its word is captured. The bench applies a word just after a rising edge, and the result is read at the falling edge that follows the next rising edge. The monitor holds the `inValid` it saw one falling edge earlier and compares it with `outValid`. For each valid result it pops the next expected header and payload from the queue. The expected payload comes from a bit-serial model that keeps its own 58-bit history. In idle cycles the monitor checks that `outData` has not moved since the last falling edge.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic clear;     // synchronous clear of history and outputs
    logic step;      // accept the presented word this cycle
    logic useInput;  // history is fed from the received bits (descramble)
  } strobe_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             descramble,
  output scr_pkg::strobe_t ctl,
  output logic             outValid
);
  logic validQ;

  always_comb begin
    ctl.clear    = rst;
    ctl.step     = inValid & ~rst;
    ctl.useInput = descramble;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

  assign outValid = validQ;
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath #(
  parameter int DATA_W   = 64,
  parameter int HDR_W    = 2,
  parameter int TAP_NEAR = 39,
  parameter int TAP_FAR  = 58
) (
  input  logic              clk,
  input  scr_pkg::strobe_t  ctl,
  input  logic [HDR_W-1:0]  inHeader,
  input  logic [DATA_W-1:0] inData,
  output logic [HDR_W-1:0]  outHeader,
  output logic [DATA_W-1:0] outData
);
  // History holds the last STATE_W line bits: stateQ[j] is bit (j + PAD) of
  // the previous word, so stateQ[0] lies TAP_FAR bits before bit 0 of this one.
  localparam int STATE_W = TAP_FAR;
  localparam int PAD     = DATA_W - STATE_W;
  localparam int GAP     = TAP_FAR - TAP_NEAR;

  logic [STATE_W-1:0] stateQ;
  logic [DATA_W-1:0]  stateExt;
  logic [DATA_W-1:0]  histTerm;
  logic [DATA_W-1:0]  scrSeed;
  logic [DATA_W-1:0]  scrWord;
  logic [DATA_W-1:0]  descWord;
  logic [DATA_W-1:0]  resWord;
  logic [STATE_W-1:0] stateNext;

  always_comb begin
    stateExt = {{PAD{1'b0}}, stateQ};
    // Contribution of earlier words to both taps, bit-aligned to this word.
    histTerm = stateExt ^ (stateExt >> GAP);
    // Scramble: fold the in-word feedback once; valid while DATA_W <= 2*TAP_NEAR.
    scrSeed  = inData ^ histTerm;
    scrWord  = scrSeed ^ (scrSeed << TAP_NEAR) ^ (scrSeed << TAP_FAR);
    // Descramble: purely feed-forward over received bits.
    descWord = inData ^ (inData << TAP_NEAR) ^ (inData << TAP_FAR) ^ histTerm;
    resWord  = ctl.useInput ? descWord : scrWord;
    stateNext = ctl.useInput ? inData[DATA_W-1 -: STATE_W]
                             : scrWord[DATA_W-1 -: STATE_W];
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      stateQ    <= '0;
      outData   <= '0;
      outHeader <= '0;
    end else if (ctl.step) begin
      stateQ    <= stateNext;
      outData   <= resWord;
      outHeader <= inHeader;
    end
  end
endmodule

// File: rtl/blk_scrambler64.sv
module blk_scrambler64 #(
  parameter int DATA_W   = 64,
  parameter int HDR_W    = 2,
  parameter int TAP_NEAR = 39,
  parameter int TAP_FAR  = 58
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              descramble,
  input  logic [HDR_W-1:0]  inHeader,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [HDR_W-1:0]  outHeader,
  output logic [DATA_W-1:0] outData
);
  scr_pkg::strobe_t ctl;

  scr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .descramble (descramble),
    .ctl        (ctl),
    .outValid   (outValid)
  );

  scr_datapath #(
    .DATA_W   (DATA_W),
    .HDR_W    (HDR_W),
    .TAP_NEAR (TAP_NEAR),
    .TAP_FAR  (TAP_FAR)
  ) u_dp (
    .clk       (clk),
    .ctl       (ctl),
    .inHeader  (inHeader),
    .inData    (inData),
    .outHeader (outHeader),
    .outData   (outData)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int DATA_W = 64,
  parameter int HDR_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              descramble,
  input logic [HDR_W-1:0]  inHeader,
  input logic [DATA_W-1:0] inData,
  input logic              outValid,
  input logic [HDR_W-1:0]  outHeader,
  input logic [DATA_W-1:0] outData
);
  // Last accepted word was an all-zero word received in descramble mode.
  logic prevZeroDesc;

  always_ff @(posedge clk) begin
    if (rst)          prevZeroDesc <= 1'b0;
    else if (inValid) prevZeroDesc <= descramble && (inData == '0);
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);  // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);  // R2
  AST_HDR_PASS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (outHeader == $past(inHeader)));  // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(outData) && $stable(outHeader)));  // R7
  AST_SELF_SYNC: assert property (@(posedge clk) disable iff (rst)
    (inValid && descramble && (inData == '0) && prevZeroDesc) |=> (outData == '0));  // R8
endmodule

bind blk_scrambler64 scr_checker #(.DATA_W(DATA_W), .HDR_W(HDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .descramble (descramble),
  .inHeader   (inHeader),
  .inData     (inData),
  .outValid   (outValid),
  .outHeader  (outHeader),
  .outData    (outData)
);

// File: tb/blk_scrambler64_test.sv
module blk_scrambler64_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        descramble = 1'b0;
  logic [1:0]  inHeader = '0;
  logic [63:0] inData = '0;
  logic        outValid;
  logic [1:0]  outHeader;
  logic [63:0] outData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit monOn = 1'b0;
  bit pendValid = 1'b0;
  logic [63:0] lastData = '0;

  logic [57:0] modelSt = '0;   // serial model of the design history
  logic [57:0] encSt;          // independent far-end scrambler
  logic [63:0] expData[$];
  logic [1:0]  expHdr[$];
  string       expTag[$];

  always #4 clk = ~clk;  // 125 MHz

  blk_scrambler64 uut (
    .clk(clk), .rst(rst), .inValid(inValid), .descramble(descramble),
    .inHeader(inHeader), .inData(inData),
    .outValid(outValid), .outHeader(outHeader), .outData(outData)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bit-serial reference: bit 0 first, taps at s[38] and s[57], newest in s[0].
  task automatic serialStep(input logic [63:0] din, input bit descr,
                            inout logic [57:0] st, output logic [63:0] dout);
    for (int i = 0; i < 64; i++) begin
      logic o;
      o = din[i] ^ st[38] ^ st[57];
      dout[i] = o;
      st = {st[56:0], descr ? din[i] : o};
    end
  endtask

  task automatic sendWord(input logic [63:0] d, input bit descr, input logic [1:0] h,
                          input string tag, input bit usePlain, input logic [63:0] plain);
    logic [63:0] res;
    serialStep(d, descr, modelSt, res);
    expData.push_back(usePlain ? plain : res);
    expHdr.push_back(h);
    expTag.push_back(tag);
    @(posedge clk); #1;
    inValid = 1'b1; descramble = descr; inHeader = h; inData = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      inValid = 1'b0;
      inData = {$urandom, $urandom};      // garbage must be ignored (R7)
      inHeader = 2'($urandom);
      descramble = 1'($urandom);
    end
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    monOn = 1'b0; rst = 1'b1; inValid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    modelSt = '0;
    @(negedge clk);
    check(outValid === 1'b0, "R1 outValid after reset", 64'(outValid), 64'd0);
    check(outData === 64'd0, "R1 outData after reset", outData, 64'd0);
    check(outHeader === 2'd0, "R1 outHeader after reset", 64'(outHeader), 64'd0);
    lastData = '0; pendValid = 1'b0; monOn = 1'b1;
  endtask

  // Monitor / scoreboard, samples between edges.
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (monOn) begin
      check(outValid === pendValid, "R2 outValid latency", 64'(outValid), 64'(pendValid));
      if (outValid === 1'b1) begin
        if (expData.size() == 0) begin
          check(1'b0, "R6 unexpected result", outData, 64'd0);
        end else begin
          logic [63:0] ed; logic [1:0] eh; string et;
          ed = expData.pop_front(); eh = expHdr.pop_front(); et = expTag.pop_front();
          check(outData === ed, et, outData, ed);
          check(outHeader === eh, "R3 header", 64'(outHeader), 64'(eh));
        end
      end else begin
        check(outData === lastData, "R7 output held while idle", outData, lastData);
      end
      lastData = outData;
      pendValid = inValid;
    end
  end

  initial begin
    logic [63:0] plain;
    logic [63:0] cipher;
    doReset();

    // R1: zero history gives zero for zero data, then a lone bit.
    sendWord(64'd0, 1'b0, 2'b01, "R1 zero word", 1'b0, 64'd0);
    sendWord(64'd1, 1'b0, 2'b10, "R1 first word from zero state", 1'b0, 64'd0);
    sendWord(64'h8000_0000_0000_0000, 1'b0, 2'b01, "R4 top bit", 1'b0, 64'd0);
    // R4 / R6: back-to-back scramble words.
    for (int k = 0; k < 24; k++)
      sendWord({$urandom, $urandom}, 1'b0, 2'($urandom), "R4 R6 scramble stream", 1'b0, 64'd0);
    // R7: idle gaps with garbage, then continue.
    idle(3);
    sendWord(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'b10, "R7 scramble after gap", 1'b0, 64'd0);
    idle(1);
    sendWord({$urandom, $urandom}, 1'b0, 2'b01, "R7 scramble after short gap", 1'b0, 64'd0);
    // R5: descramble stream.
    for (int k = 0; k < 20; k++)
      sendWord({$urandom, $urandom}, 1'b1, 2'($urandom), "R5 descramble stream", 1'b0, 64'd0);
    // R8: far end scrambles plaintext from an unrelated history.
    encSt = {26'($urandom), $urandom};
    for (int k = 0; k < 12; k++) begin
      plain = (k == 5) ? 64'd0 : {$urandom, $urandom};
      serialStep(plain, 1'b0, encSt, cipher);
      sendWord(cipher, 1'b1, 2'b01, (k == 0) ? "R5 first locking word" : "R8 recovered plaintext",
               k != 0, plain);
      if (k == 6) idle(2);
    end
    // R9: mode alternating word by word.
    for (int k = 0; k < 16; k++)
      sendWord({$urandom, $urandom}, 1'(k % 2), 2'($urandom), "R9 mode switch", 1'b0, 64'd0);
    idle(3);
    check(expData.size() == 0, "R6 all results delivered", 64'(expData.size()), 64'd0);

    // R1: reset in mid stream clears the history.
    doReset();
    sendWord(64'h0123_4567_89AB_CDEF, 1'b0, 2'b10, "R1 scramble after mid-run reset", 1'b0, 64'd0);
    sendWord(64'h0, 1'b1, 2'b01, "R5 descramble after reset", 1'b0, 64'd0);
    idle(3);
    check(expData.size() == 0, "R6 all results delivered", 64'(expData.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule